// File: doc/BRIEF.md
# Cascadable Serial Configuration Bit Store

This block is a read-only bit store that feeds configuration data, one bit per rising clock edge, to a device that loads itself from a serial stream. An internal bit address counter selects the bit on the data output. The counter moves to the next address on a rising clock edge only when the active-low chip-enable and the combined reset/output-enable pin both select the device. While the combined pin is in its reset state, the counter returns to zero and the output stays quiet. A build parameter sets which level of that pin means reset.

A tri-state pin is modelled as a data output plus a separate drive-enable. Several stores can be chained. The chain-enable output of one store drives the chip-enable input of the next. On the clock edge after the last stored bit, a store stops driving and pulls its chain-enable low, so the next store takes over the stream with no gap. The storage is a parameterized register array. A simple write port loads it, and that port works only while the store is held in reset.

Top module: `serial_cfg_store`

## Requirements
- R1: On a rising clock edge, with chip-enable (`ce_n`) low and the reset/output-enable pin in its enabled state, the bit address advances by one. `data_out` then presents the bit at the new address before the next edge.
- R2: While the reset/output-enable pin is in its reset state, the address is held at zero, `data_oe` is 0 and `ceo_n` is 1. Reading after reset ends starts again at address 0, even if reset cut a read short.
- R3: Parameter `RST_POL`, value `RSTPOL_HIGH` (the default): `rst_oe`=1 means reset and `rst_oe`=0 means enabled. Value `RSTPOL_LOW` reverses this.
- R4: While `ce_n` is 1, the address does not change and `data_oe` is 0. `data_out` is 0 whenever `data_oe` is 0.
- R5: After the bit at address DEPTH-1 has been presented, the next qualifying edge drives `ceo_n` to 0 and `data_oe` to 0. A store chained on `ceo_n` then presents its address-0 bit.
- R6: Once the terminal count has been passed, `ceo_n` follows `ce_n` for as long as the pin stays enabled. Only entering the reset state clears this state.
- R7: If `ce_n` is raised in the middle of a read and lowered again without a reset, reading continues at the next unread address, not at zero.
- R8: After the terminal count, further edges leave the store silent (`data_oe`=0) and `ceo_n` low while `ce_n` is low. The address does not wrap.
- R9: When `wr_en` is 1 at a rising edge while the store is in reset, `wr_data` is written to address `wr_addr`. Writes outside reset, and writes to addresses at or above DEPTH, have no effect.
- R10: Bits leave in ascending address order, starting from address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read clock; rising edge advances the address |
| ce_n | input | 1 | Chip-enable, active low |
| rst_oe | input | 1 | Combined reset / output-enable, polarity set by `RST_POL` |
| wr_en | input | 1 | Preload write strobe, honoured only in reset |
| wr_addr | input | AW | Preload bit address, AW = clog2(DEPTH) |
| wr_data | input | 1 | Preload bit value |
| data_out | output | 1 | Serial data bit, 0 when not driven |
| data_oe | output | 1 | High when the store drives `data_out` |
| ceo_n | output | 1 | Chain-enable for the next store, active low |

## Verification
The bench chains two stores with opposite reset polarities on one reset line. A cycle-by-cycle model of the pair is compared with every output on every clock. The bench targets the hand-over edge: a store that releases one cycle late repeats its last bit, and one that releases early drops that bit. It lowers chip-enable again after a pause, where a store that rewinds restarts at the first bit. It also raises chip-enable after the terminal count, where a store whose chain output does not follow chip-enable leaves the next store enabled. A write attempt outside reset checks that such a write cannot corrupt a bit read later. Resetting in the middle of a read checks that a store keeping its stale address is caught.

// File: rtl/cfg_store_pkg.sv
package cfg_store_pkg;

   // Level meaning of the combined reset / output-enable pin.
   typedef enum logic {
      RSTPOL_HIGH = 1'b0,   // pin high = reset, low = enabled
      RSTPOL_LOW  = 1'b1    // pin low  = reset, high = enabled
   } rst_pol_e;

   // Address width for a store of the given number of bits.
   function automatic int unsigned store_addr_bits(int unsigned depth);
      return (depth < 2) ? 1 : $clog2(depth);
   endfunction

endpackage

// File: rtl/cfg_rst_decode.sv
module cfg_rst_decode
   import cfg_store_pkg::*;
#(
   parameter rst_pol_e RST_POL = RSTPOL_HIGH
) (
   input  logic rst_oe,
   output logic hold
);

   generate
      if (RST_POL == RSTPOL_HIGH) begin : g_high
         assign hold = rst_oe;
      end else begin : g_low
         assign hold = ~rst_oe;
      end
   endgenerate

endmodule

// File: rtl/cfg_bit_array.sv
module cfg_bit_array #(
   parameter int unsigned DEPTH = 256,
   parameter int unsigned AW    = 8
) (
   input  logic          clk,
   input  logic          wr_allow,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic          wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic          rd_bit
);

   localparam int unsigned SPAN = 1 << AW;

   logic [DEPTH-1:0] cells;
   logic             wr_in_range;
   logic             rd_in_range;

   generate
      if (SPAN == DEPTH) begin : g_full_span
         assign wr_in_range = 1'b1;
         assign rd_in_range = 1'b1;
      end else begin : g_part_span
         assign wr_in_range = (int'(wr_addr) < int'(DEPTH));
         assign rd_in_range = (int'(rd_addr) < int'(DEPTH));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_en && wr_allow && wr_in_range) begin
         cells[wr_addr] <= wr_data;
      end
   end

   assign rd_bit = rd_in_range ? cells[rd_addr] : 1'b0;

endmodule

// File: rtl/cfg_addr_counter.sv
module cfg_addr_counter #(
   parameter int unsigned DEPTH = 256,
   parameter int unsigned AW    = 8
) (
   input  logic          clk,
   input  logic          hold,
   input  logic          step,
   output logic [AW-1:0] addr,
   output logic          done
);

   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
   localparam logic [AW-1:0] ONE  = AW'(1);

   always_ff @(posedge clk or posedge hold) begin
      if (hold) begin
         addr <= '0;
         done <= 1'b0;
      end else if (step && !done) begin
         if (addr == LAST) begin
            done <= 1'b1;
         end else begin
            addr <= addr + ONE;
         end
      end
   end

   AST_HOLD_AT_ZERO: assert property (@(negedge clk)
      hold |-> (addr == '0 && !done)); // R2

   AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (hold)
      (step && !done && addr != LAST) |=> (addr == $past(addr) + ONE)); // R1

   AST_FROZEN_IDLE: assert property (@(posedge clk) disable iff (hold)
      !step |=> ($stable(addr) && $stable(done))); // R4

   AST_TC_REACHED: assert property (@(posedge clk) disable iff (hold)
      (step && !done && addr == LAST) |=> done); // R5

   AST_NO_WRAP: assert property (@(posedge clk) disable iff (hold)
      done |=> (done && addr == LAST)); // R8

endmodule

// File: rtl/cfg_chain_ctrl.sv
module cfg_chain_ctrl (
   input  logic ce_n,
   input  logic hold,
   input  logic done,
   input  logic cell_bit,
   output logic step,
   output logic data_out,
   output logic data_oe,
   output logic ceo_n
);

   logic selected;

   assign selected = ~ce_n & ~hold;
   assign step     = selected;
   assign data_oe  = selected & ~done;
   assign data_out = data_oe & cell_bit;
   assign ceo_n    = ~(selected & done);

endmodule

// File: rtl/serial_cfg_store.sv
module serial_cfg_store
   import cfg_store_pkg::*;
#(
   parameter int unsigned DEPTH   = 256,
   parameter rst_pol_e    RST_POL = RSTPOL_HIGH,
   localparam int unsigned AW     = store_addr_bits(DEPTH)
) (
   input  logic          clk,
   input  logic          ce_n,
   input  logic          rst_oe,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic          wr_data,
   output logic          data_out,
   output logic          data_oe,
   output logic          ceo_n
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         initial $error("serial_cfg_store: DEPTH must be at least 2");
      end
   endgenerate

   logic          hold;
   logic          step;
   logic          done;
   logic [AW-1:0] addr;
   logic          cell_bit;

   cfg_rst_decode #(.RST_POL(RST_POL)) u_rst (
      .rst_oe (rst_oe),
      .hold   (hold)
   );

   cfg_bit_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
      .clk      (clk),
      .wr_allow (hold),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_addr  (addr),
      .rd_bit   (cell_bit)
   );

   cfg_addr_counter #(.DEPTH(DEPTH), .AW(AW)) u_count (
      .clk  (clk),
      .hold (hold),
      .step (step),
      .addr (addr),
      .done (done)
   );

   cfg_chain_ctrl u_chain (
      .ce_n     (ce_n),
      .hold     (hold),
      .done     (done),
      .cell_bit (cell_bit),
      .step     (step),
      .data_out (data_out),
      .data_oe  (data_oe),
      .ceo_n    (ceo_n)
   );

   AST_RESET_QUIET: assert property (@(negedge clk)
      hold |-> (!data_oe && ceo_n)); // R2

   AST_SINGLE_OWNER: assert property (@(negedge clk)
      !(data_oe && !ceo_n)); // R5

   AST_CEO_NEEDS_CE: assert property (@(negedge clk)
      !ceo_n |-> !ce_n); // R6

   AST_QUIET_ZERO: assert property (@(negedge clk)
      !data_oe |-> !data_out); // R4

endmodule

// File: tb/sim_serial_cfg_store.sv
module sim_serial_cfg_store;
   import cfg_store_pkg::*;

   localparam int D0 = 16;
   localparam int D1 = 12;
   localparam logic [15:0] PAT0 = 16'hB4E1;
   localparam logic [11:0] PAT1 = 12'hA5C;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic       rst_h, ce_n0, wr_en0, wr_en1, wr_data;
   logic [3:0] wr_addr;
   logic       d0, oe0, ceo0, d1, oe1, ceo1;

   serial_cfg_store #(.DEPTH(D0), .RST_POL(RSTPOL_HIGH)) u0 (
      .clk(clk), .ce_n(ce_n0), .rst_oe(rst_h), .wr_en(wr_en0),
      .wr_addr(wr_addr), .wr_data(wr_data),
      .data_out(d0), .data_oe(oe0), .ceo_n(ceo0));

   serial_cfg_store #(.DEPTH(D1), .RST_POL(RSTPOL_LOW)) u1 (
      .clk(clk), .ce_n(ceo0), .rst_oe(~rst_h), .wr_en(wr_en1),
      .wr_addr(wr_addr), .wr_data(wr_data),
      .data_out(d1), .data_oe(oe1), .ceo_n(ceo1));

   int    checks = 0;
   int    fails  = 0;
   string cur_req = "R2";
   bit    armed = 1'b0;
   bit    finished = 1'b0;

   bit mem0 [D0];
   bit mem1 [D1];
   int p0 = 0;
   int p1 = 0;

   task automatic chk(string req, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   // Behavioural model of the two-store chain, updated on each rising edge.
   always @(posedge clk) begin
      bit en0, en1;
      if (rst_h) begin
         if (wr_en0) mem0[wr_addr] = wr_data;
         if (wr_en1 && int'(wr_addr) < D1) mem1[wr_addr] = wr_data;
         p0 = 0;
         p1 = 0;
      end else begin
         en0 = !ce_n0;
         en1 = en0 && (p0 == D0);
         if (en0 && p0 < D0) p0++;
         if (en1 && p1 < D1) p1++;
      end
   end

   // Compare every output against the model, away from the active edge.
   always @(negedge clk) begin
      logic en, c0, c1, e_oe0, e_d0, e_ceo0, e_oe1, e_d1, e_ceo1;
      if (armed && !finished) begin
         en     = !rst_h;
         c0     = !ce_n0;
         e_oe0  = en && c0 && (p0 < D0);
         e_d0   = e_oe0 ? mem0[(p0 < D0) ? p0 : 0] : 1'b0;
         e_ceo0 = !(en && c0 && (p0 == D0));
         c1     = !e_ceo0;
         e_oe1  = en && c1 && (p1 < D1);
         e_d1   = e_oe1 ? mem1[(p1 < D1) ? p1 : 0] : 1'b0;
         e_ceo1 = !(en && c1 && (p1 == D1));
         chk(cur_req, "u0.data_out", d0, e_d0);
         chk(cur_req, "u0.data_oe", oe0, e_oe0);
         chk(cur_req, "u0.ceo_n", ceo0, e_ceo0);
         chk(cur_req, "u1.data_out", d1, e_d1);
         chk(cur_req, "u1.data_oe", oe1, e_oe1);
         chk(cur_req, "u1.ceo_n", ceo1, e_ceo1);
      end
   end

   task automatic cyc(int n);
      repeat (n) begin
         @(posedge clk);
         #5;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_h = 1'b1; ce_n0 = 1'b1; wr_en0 = 1'b0; wr_en1 = 1'b0;
      wr_addr = '0; wr_data = 1'b0;
      cyc(2);
      armed = 1'b1;

      // R2: reset state, even with chip-enable active
      cur_req = "R2";
      #1;
      chk("R2", "reset u0.data_oe", oe0, 1'b0);
      chk("R2", "reset u0.ceo_n", ceo0, 1'b1);
      chk("R2", "reset u1.ceo_n", ceo1, 1'b1);
      ce_n0 = 1'b0;
      cyc(2);
      chk("R2", "reset ce low u0.data_oe", oe0, 1'b0);
      chk("R2", "reset ce low u0.data_out", d0, 1'b0);
      ce_n0 = 1'b1;

      // R9: preload both stores during reset
      cur_req = "R9";
      for (int i = 0; i < D0; i++) begin
         wr_en0 = 1'b1; wr_addr = 4'(i); wr_data = PAT0[i];
         cyc(1);
      end
      wr_en0 = 1'b0;
      for (int i = 0; i < D1; i++) begin
         wr_en1 = 1'b1; wr_addr = 4'(i); wr_data = PAT1[i];
         cyc(1);
      end
      wr_en1 = 1'b1; wr_addr = 4'd13; wr_data = 1'b1;   // beyond DEPTH of u1
      cyc(1);
      wr_en1 = 1'b0;

      // R3/R4: leave reset (u1 sees the inverted level), chip-enable idle
      cur_req = "R4";
      rst_h = 1'b0;
      cyc(3);
      chk("R4", "idle u0.data_oe", oe0, 1'b0);
      chk("R4", "idle u0.data_out", d0, 1'b0);
      chk("R3", "idle u0.ceo_n", ceo0, 1'b1);
      chk("R3", "idle u1.data_oe", oe1, 1'b0);

      // R1/R10: first bits in ascending order
      cur_req = "R1";
      ce_n0 = 1'b0;
      for (int k = 0; k < 5; k++) begin
         #1;
         chk("R10", "u0 bit order", d0, PAT0[k]);
         chk("R1", "u0 driving", oe0, 1'b1);
         cyc(1);
      end

      // R4 pause, with a write attempt outside reset (R9)
      cur_req = "R4";
      ce_n0 = 1'b1;
      cyc(1);
      wr_en0 = 1'b1; wr_addr = 4'd9; wr_data = ~PAT0[9];
      cyc(1);
      wr_en0 = 1'b0;
      cyc(1);
      chk("R4", "paused u0.data_oe", oe0, 1'b0);

      // R7: resume from the next unread bit
      cur_req = "R7";
      ce_n0 = 1'b0;
      for (int k = 5; k < D0; k++) begin
         #1;
         if (k == 5)      chk("R7", "resume bit", d0, PAT0[k]);
         else if (k == 9) chk("R9", "write outside reset ignored", d0, PAT0[k]);
         else             chk("R10", "u0 bit order", d0, PAT0[k]);
         cyc(1);
      end

      // R5: hand-over to the next store
      cur_req = "R5";
      #1;
      chk("R5", "u0 stops driving", oe0, 1'b0);
      chk("R5", "u0.ceo_n low", ceo0, 1'b0);
      chk("R5", "u1 takes over", oe1, 1'b1);
      for (int k = 0; k < D1; k++) begin
         #1;
         chk("R10", "u1 bit order", d1, PAT1[k]);
         cyc(1);
      end

      // R8: past the end of the chain
      cur_req = "R8";
      cyc(3);
      chk("R8", "u1 silent", oe1, 1'b0);
      chk("R8", "u1.ceo_n low", ceo1, 1'b0);
      chk("R8", "u0 silent", oe0, 1'b0);

      // R6: chain-enable follows chip-enable, cleared by reset
      cur_req = "R6";
      ce_n0 = 1'b1;
      #1;
      chk("R6", "u0.ceo_n follows ce_n high", ceo0, 1'b1);
      chk("R6", "u1.ceo_n follows", ceo1, 1'b1);
      cyc(2);
      ce_n0 = 1'b0;
      #1;
      chk("R6", "u0.ceo_n follows ce_n low", ceo0, 1'b0);
      chk("R8", "u0 still silent", oe0, 1'b0);
      rst_h = 1'b1;
      #1;
      chk("R6", "reset clears u0.ceo_n", ceo0, 1'b1);
      cyc(1);
      rst_h = 1'b0;
      #1;
      chk("R6", "u0.ceo_n stays high after reset", ceo0, 1'b1);
      chk("R2", "restart from address 0", d0, PAT0[0]);
      chk("R2", "u0 driving again", oe0, 1'b1);

      // R2: reset in the middle of a read
      cur_req = "R2";
      cyc(4);
      #1;
      chk("R1", "mid-read bit", d0, PAT0[4]);
      rst_h = 1'b1;
      cyc(1);
      rst_h = 1'b0;
      #1;
      chk("R2", "mid-read reset rewinds", d0, PAT0[0]);
      cyc(3);
      #1;
      chk("R1", "after rewind", d0, PAT0[3]);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule